// File: doc/BRIEF.md
# Streaming Three-Point DFT Engine

This block computes a three-point discrete Fourier transform on a stream of complex fixed-point samples that arrive one per clock cycle. Every three accepted samples form a group (x0, x1, x2, in arrival order). The block returns the three transform bins X0, X1 and X2 on three consecutive cycles. The bins are computed with real add/subtract steps spread over a short pipeline. The 120-degree rotations are built from a sum, a difference, a halving and a scaling by a fixed constant close to sqrt(3)/2. That scaling is a chain of shifts and subtractions, so the block contains no hardware multiplier.

It is meant to sit as a processing element inside a larger serial FFT pipeline. The neighbouring stage supplies samples with a valid strobe, and this block hands results on with its own strobe. Gaps in the input stream are allowed: a cycle with the valid strobe low contributes nothing. Groups may follow each other with no idle cycle, which sustains one sample per cycle in and out.

Top module: `serial_r3_butterfly`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is asserted and after it is released with no input, `outValid` is 0 and `outRe`/`outIm` are 0. The group position restarts at x0.
- R2: Data are signed two's complement, `W` bits in and `W+2` bits out. The first result of a group is X0 = x0 + x1 + x2, computed separately for the real and imaginary parts.
- R3: The second result is X1. Its real part is Mr + K(di) and its imaginary part is Mi − K(dr). Here M = x0 − floor((x1 + x2)/2) per component, d = x1 − x2 per component, and K is the scaling of R6.
- R4: The third result is X2. Its real part is Mr − K(di) and its imaginary part is Mi + K(dr).
- R5: The halving in M is an arithmetic right shift, so it rounds toward minus infinity. For example, x1 + x2 = −3 gives −2.
- R6: The constant scaling is K(v) = floor(887·v/1024), built from shifts and subtractions only. For example, K(1) = 0 and K(−1) = −1.
- R7: X0 is registered on the second clock edge after the edge that accepts x2. X1 and X2 follow on the next two edges, and `outValid` is high for exactly those three cycles per group. With a gap-free input this places X0 four cycles after x0.
- R8: A cycle with `inValid` low is ignored. The data on the bus during that cycle has no effect on any result, and the group position does not advance.
- R9: Groups presented back to back, with no idle cycle, are all processed at one sample per cycle. The three-cycle output bursts then abut, with no lost or repeated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample strobe |
| inRe | input | W | Input real part, signed |
| inIm | input | W | Input imaginary part, signed |
| outValid | output | 1 | Output result strobe |
| outRe | output | W+2 | Output real part, signed |
| outIm | output | W+2 | Output imaginary part, signed |

## Verification
The embedded properties watch the control on every cycle:
- the group position stays in its three legal values and freezes on idle cycles;
- every output burst lasts three cycles;
- the bin selector steps strictly X0, X1, X2;
- X0 appears two edges after a group completes.

Only the bench scenarios can show the arithmetic itself. These include the floor behaviour of the halving and of the constant scaling on odd and negative values, full-scale corner groups, groups split by idle cycles carrying junk data, and long back-to-back runs whose results are compared against reference functions.

// File: rtl/bf3_pkg.sv
package bf3_pkg;

  // Strobes issued by the sequencer to the arithmetic path each cycle.
  typedef struct packed {
    logic       capFirst;   // register sample x0
    logic       capSecond;  // register sample x1
    logic       fire;       // x2 present: load sum/difference stage
    logic       advance;    // load product/midpoint stage
    logic       emit;       // load output register
    logic [1:0] binSel;     // 0: X0, 1: X1, 2: X2
  } bf3Strobe_t;

  localparam logic [1:0] BIN_X0 = 2'd0;
  localparam logic [1:0] BIN_X1 = 2'd1;
  localparam logic [1:0] BIN_X2 = 2'd2;

endpackage

// File: rtl/sqrt3half_shiftadd.sv
// floor(v * 887 / 1024) from three shift-and-subtract steps:
// 887 = ((8 - 1) * 16 - 1) * 8 - 1
module sqrt3half_shiftadd #(
  parameter int DW = 13
) (
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] dout
);
  localparam int PW = DW + 10;
  localparam int FRAC = 10;

  logic signed [PW-1:0] ext;
  logic signed [PW-1:0] times7;
  logic signed [PW-1:0] times111;
  logic signed [PW-1:0] times887;
  logic signed [PW-1:0] scaled;

  always_comb begin
    ext      = PW'(din);
    times7   = (ext <<< 3) - ext;
    times111 = (times7 <<< 4) - ext;
    times887 = (times111 <<< 3) - ext;
    scaled   = times887 >>> FRAC;
    dout     = DW'(scaled);
  end
endmodule

// File: rtl/bf3_ctrl.sv
module bf3_ctrl
  import bf3_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output bf3Strobe_t strobe
);
  logic [1:0] inPhase;
  logic       stage1Full;
  logic       stage2Full;
  logic       burstOn;
  logic [1:0] burstIdx;

  always_comb begin
    strobe.capFirst  = inValid && (inPhase == 2'd0);
    strobe.capSecond = inValid && (inPhase == 2'd1);
    strobe.fire      = inValid && (inPhase == 2'd2);
    strobe.advance   = stage1Full;
    strobe.emit      = stage2Full || burstOn;
    strobe.binSel    = stage2Full ? BIN_X0 : burstIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPhase <= 2'd0;
    end else if (inValid) begin
      inPhase <= (inPhase == 2'd2) ? 2'd0 : inPhase + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Full <= 1'b0;
      stage2Full <= 1'b0;
    end else begin
      stage1Full <= strobe.fire;
      stage2Full <= stage1Full;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn  <= 1'b0;
      burstIdx <= BIN_X0;
    end else if (stage2Full) begin
      burstOn  <= 1'b1;
      burstIdx <= BIN_X1;
    end else if (burstOn) begin
      if (burstIdx == BIN_X2) begin
        burstOn  <= 1'b0;
        burstIdx <= BIN_X0;
      end else begin
        burstIdx <= burstIdx + 2'd1;
      end
    end
  end

  // R8: group position only takes legal values
  p_phase_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    inPhase != 2'd3);

  // R8: idle input cycles leave the group position untouched
  p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(inPhase));

  // R7: a completed group produces its X0 two edges later
  p_x0_after_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fire |=> ##1 (strobe.emit && strobe.binSel == BIN_X0));

  // R7: bins leave in the order X0, X1, X2
  p_bin_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.binSel != BIN_X0) |->
      ($past(strobe.emit) && $past(strobe.binSel) == strobe.binSel - 2'd1));

endmodule

// File: rtl/bf3_datapath.sv
module bf3_datapath
  import bf3_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bf3Strobe_t            strobe,
  input  logic signed [W-1:0]   inRe,
  input  logic signed [W-1:0]   inIm,
  output logic                  outValid,
  output logic signed [W+1:0]   outRe,
  output logic signed [W+1:0]   outIm
);
  localparam int SW = W + 1;  // width of x1+x2 and x1-x2
  localparam int OW = W + 2;  // result width
  localparam int NC = 2;      // component 0 = real, 1 = imaginary

  logic signed [W-1:0]  curIn   [NC];
  logic signed [W-1:0]  firstQ  [NC];
  logic signed [W-1:0]  secondQ [NC];
  logic signed [W-1:0]  holdX0  [NC];
  logic signed [SW-1:0] sumQ    [NC];
  logic signed [SW-1:0] diffQ   [NC];
  logic signed [SW-1:0] scaledD [NC];
  logic signed [OW-1:0] binX0   [NC];
  logic signed [OW-1:0] midQ    [NC];
  logic signed [SW-1:0] rotQ    [NC];
  logic signed [OW-1:0] nextOut [NC];

  assign curIn[0] = inRe;
  assign curIn[1] = inIm;

  for (genvar c = 0; c < NC; c++) begin : g_comp
    // input reorder registers: hold x0 and x1 until x2 arrives
    always_ff @(posedge clk) begin
      if (strobe.capFirst)  firstQ[c]  <= curIn[c];
      if (strobe.capSecond) secondQ[c] <= curIn[c];
    end

    // stage 1: pair sum and pair difference, x0 carried along
    always_ff @(posedge clk) begin
      if (strobe.fire) begin
        holdX0[c] <= firstQ[c];
        sumQ[c]   <= SW'(secondQ[c]) + SW'(curIn[c]);
        diffQ[c]  <= SW'(secondQ[c]) - SW'(curIn[c]);
      end
    end

    sqrt3half_shiftadd #(.DW(SW)) u_scale (
      .din  (diffQ[c]),
      .dout (scaledD[c])
    );

    // stage 2: DC bin, midpoint, scaled difference
    always_ff @(posedge clk) begin
      if (strobe.advance) begin
        binX0[c] <= OW'(holdX0[c]) + OW'(sumQ[c]);
        midQ[c]  <= OW'(holdX0[c]) - OW'(sumQ[c] >>> 1);
        rotQ[c]  <= scaledD[c];
      end
    end
  end

  // stage 3: one shared adder per component, sign chosen by bin.
  // Rotation by -j/+j swaps components: real uses imag scaled term, imag uses real.
  always_comb begin
    nextOut[0] = binX0[0];
    nextOut[1] = binX0[1];
    if (strobe.binSel == BIN_X1) begin
      nextOut[0] = midQ[0] + OW'(rotQ[1]);
      nextOut[1] = midQ[1] - OW'(rotQ[0]);
    end else if (strobe.binSel == BIN_X2) begin
      nextOut[0] = midQ[0] - OW'(rotQ[1]);
      nextOut[1] = midQ[1] + OW'(rotQ[0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRe    <= '0;
      outIm    <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outRe <= nextOut[0];
        outIm <= nextOut[1];
      end
    end
  end

  // R7: every burst on the output lasts exactly three cycles
  p_burst_three_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |=> outValid ##1 outValid);

  // R7: output data only change when a result is loaded
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outRe) || $past(!rstN));

endmodule

// File: rtl/serial_r3_butterfly.sv
module serial_r3_butterfly
  import bf3_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic signed [W-1:0] inRe,
  input  logic signed [W-1:0] inIm,
  output logic                outValid,
  output logic signed [W+1:0] outRe,
  output logic signed [W+1:0] outIm
);
  bf3Strobe_t strobe;

  bf3_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  bf3_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inRe     (inRe),
    .inIm     (inIm),
    .outValid (outValid),
    .outRe    (outRe),
    .outIm    (outIm)
  );
endmodule

// File: tb/tb_serial_r3_butterfly.sv
`timescale 1ns/1ps
module tb_serial_r3_butterfly;
  localparam int W = 12;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [W-1:0] inRe = '0;
  logic signed [W-1:0] inIm = '0;
  logic outValid;
  logic signed [W+1:0] outRe;
  logic signed [W+1:0] outIm;

  serial_r3_butterfly #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .outValid(outValid), .outRe(outRe), .outIm(outIm)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int expRe [DEPTH];
  int expIm [DEPTH];
  int expCyc[DEPTH];
  string expTag[DEPTH];
  int wrPtr = 0;
  int rdPtr = 0;

  int gRe[3];
  int gIm[3];
  int lastEdge;

  function automatic int halfFloor(int v);
    return v >>> 1;
  endfunction

  function automatic int kScale(int v);
    return (887 * v) >>> 10;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one sample, preceded by idle cycles carrying junk on the bus (R8)
  task automatic sendSample(int re, int im, int gaps);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      inValid = 1'b0;
      inRe = W'($urandom);
      inIm = W'($urandom);
    end
    @(negedge clk);
    inValid = 1'b1;
    inRe = W'(re);
    inIm = W'(im);
    lastEdge = cyc + 1;
  endtask

  task automatic sendGroup(int maxGap, string tag);
    int mRe, mIm, dRe, dIm, sRe, sIm;
    for (int i = 0; i < 3; i++)
      sendSample(gRe[i], gIm[i], (maxGap > 0) ? $urandom_range(maxGap, 0) : 0);
    sRe = gRe[1] + gRe[2];
    sIm = gIm[1] + gIm[2];
    dRe = gRe[1] - gRe[2];
    dIm = gIm[1] - gIm[2];
    mRe = gRe[0] - halfFloor(sRe);
    mIm = gIm[0] - halfFloor(sIm);
    expRe[wrPtr] = gRe[0] + sRe;         expIm[wrPtr] = gIm[0] + sIm;
    expRe[wrPtr+1] = mRe + kScale(dIm);  expIm[wrPtr+1] = mIm - kScale(dRe);
    expRe[wrPtr+2] = mRe - kScale(dIm);  expIm[wrPtr+2] = mIm + kScale(dRe);
    for (int i = 0; i < 3; i++) begin
      expCyc[wrPtr+i] = lastEdge + 2 + i;
      expTag[wrPtr+i] = tag;
    end
    wrPtr += 3;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic setGroup(int r0, int i0, int r1, int i1, int r2, int i2);
    gRe[0] = r0; gIm[0] = i0; gRe[1] = r1; gIm[1] = i1; gRe[2] = r2; gIm[2] = i2;
  endtask

  // monitor: value checks name R2/R3/R4 by bin, timing check names R7
  always @(negedge clk) begin
    if (rstN && outValid && !done) begin
      if (rdPtr >= wrPtr) begin
        check(1'b0, "R7 unexpected outValid", 1, 0);
      end else begin
        string binReq;
        case (rdPtr % 3)
          0: binReq = "R2";
          1: binReq = "R3";
          default: binReq = "R4";
        endcase
        check(int'(outRe) == expRe[rdPtr], {binReq, " re ", expTag[rdPtr]}, int'(outRe), expRe[rdPtr]);
        check(int'(outIm) == expIm[rdPtr], {binReq, " im ", expTag[rdPtr]}, int'(outIm), expIm[rdPtr]);
        check(cyc == expCyc[rdPtr], {"R7 timing ", expTag[rdPtr]}, cyc, expCyc[rdPtr]);
        rdPtr++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int seedV;
    int x0EdgeChk;
    seedV = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(outRe == '0, "R1 outRe in reset", int'(outRe), 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(4);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(outIm == '0, "R1 outIm after reset", int'(outIm), 0);

    // basic group, gap free: X0 four cycles after x0 (R7)
    setGroup(100, -20, 30, 40, -50, 7);
    sendGroup(0, "basic");
    x0EdgeChk = lastEdge - 2;
    idle(8);
    check(expCyc[0] == x0EdgeChk + 4, "R7 X0 four cycles after x0", expCyc[0], x0EdgeChk + 4);

    // R5: odd negative pair sum rounds down
    setGroup(0, 0, -3, -1, 0, 0);
    sendGroup(0, "R5 floor half");
    idle(6);

    // R6: scaling of +1 and -1
    setGroup(0, 0, 1, -1, 0, 0);
    sendGroup(0, "R6 scale unit");
    idle(6);

    // full-scale corners
    setGroup(-2048, -2048, -2048, -2048, -2048, -2048);
    sendGroup(0, "corner min");
    setGroup(2047, -2048, -2048, 2047, 2047, -2048);
    sendGroup(0, "corner mixed");
    setGroup(2047, 2047, 2047, 2047, 2047, 2047);
    sendGroup(0, "corner max");
    idle(6);

    // R8: groups split by idle cycles with junk data
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 3; i++) begin
        gRe[i] = $urandom_range(4095, 0) - 2048;
        gIm[i] = $urandom_range(4095, 0) - 2048;
      end
      sendGroup(3, "R8 gapped");
    end
    idle(8);

    // R9: long back-to-back run
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < 3; i++) begin
        gRe[i] = $urandom_range(4095, 0) - 2048;
        gIm[i] = $urandom_range(4095, 0) - 2048;
      end
      sendGroup(0, "R9 back to back");
    end
    idle(10);

    check(rdPtr == wrPtr, "R9 all results delivered", rdPtr, wrPtr);
    check(outValid == 1'b0, "R7 burst ended", int'(outValid), 0);
    done = 1'b1;
    report();
  end
endmodule